// File: doc/BRIEF.md
# Memory Dependency Ordering Queue

This block sits between address generation and the vector and matrix execution units. Every instruction that touches on-chip memory is written into it in program order. With the instruction comes the region it accesses (a start address and a byte count), a flag telling whether it writes that region, and a tag. The queue offers its oldest not-yet-dispatched entry to the execution side. It holds that entry back while any older entry that is still outstanding touches an overlapping region and either of the two writes. This turns variable-length memory operands into safe in-order dispatch without comparing register names.

Entries pass through three states: waiting, issued and completed. A completion report names an issued entry by its tag. Completed entries leave from the head, one per cycle and strictly in order. Entries that are waiting or issued block later conflicting accesses. Completed entries no longer block anything.

Top module: `mdq_top`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `dsp_valid` is 0.
- R2: The dispatch port shows the base, size, write flag and tag of the oldest waiting entry. An entry is dispatched when `dsp_valid` and `dsp_ready` are both 1 at a clock edge. At most one entry is dispatched per cycle.
- R3: The oldest waiting entry is held (`dsp_valid` = 0) while an older waiting or issued entry has an overlapping region and at least one of the two is a write. This covers read after write, write after read and write after write.
- R4: Two reads with overlapping regions never hold each other back.
- R5: Regions are half-open. [a, a+s) and [b, b+t) overlap exactly when a < b+t and b < a+s, with the sums taken without wrap-around. Regions that only touch do not conflict. A one-byte overlap does conflict.
- R6: A region of size 0 conflicts with nothing.
- R7: Dispatch is in program order. A younger independent entry is not offered while an older waiting entry is held.
- R8: A completion (`cmp_valid` with `cmp_tag`) marks the issued entry with that tag as completed. From the following cycle, that entry no longer holds back any other entry.
- R9: Entries are freed only from the head and only once completed, one per cycle. The head is freed on the clock edge after the one that recorded its completion. `full` and `empty` change on that same edge.
- R10: The queue holds DEPTH entries (default 8). `full` is 1 while DEPTH entries are held. An enqueue offered while `full` is 1 is dropped and never appears at dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Enqueue request, taken when `full` is 0 |
| enq_base | input | ADDR_W | Start address of the access region |
| enq_size | input | SIZE_W | Byte count of the region |
| enq_write | input | 1 | 1 = write access, 0 = read access |
| enq_tag | input | TAG_W | Identifier returned on completion |
| dsp_valid | output | 1 | Oldest waiting entry is free of hazards |
| dsp_ready | input | 1 | Execution side accepts the offered entry |
| dsp_base | output | ADDR_W | Base of the offered entry |
| dsp_size | output | SIZE_W | Size of the offered entry |
| dsp_write | output | 1 | Write flag of the offered entry |
| dsp_tag | output | TAG_W | Tag of the offered entry |
| cmp_valid | input | 1 | Completion report |
| cmp_tag | input | TAG_W | Tag of the completed issued entry |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entries |

## Verification
The bench builds the block with the defaults: eight slots, 16-bit addresses, 8-bit sizes and 4-bit tags. Because the queue is shallow, a run of plain enqueues fills it, so the refused enqueue and the recovery after draining are both reached. Because tags are narrow, tag values are reused once earlier entries have retired. The 16-bit address space lets the tests place touching, one-byte-overlapping and empty regions next to writes that are in flight. With this layout, the head-only retirement order can be observed through `full`.

// File: rtl/mdq_pkg.sv
package mdq_pkg;

  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ISS  = 2'd2,
    ST_DONE = 2'd3
  } slot_st_e;

endpackage

// File: rtl/mdq_overlap.sv
module mdq_overlap #(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 8
) (
  input  logic [ADDR_W-1:0] a_base,
  input  logic [SIZE_W-1:0] a_size,
  input  logic              a_wr,
  input  logic [ADDR_W-1:0] b_base,
  input  logic [SIZE_W-1:0] b_size,
  input  logic              b_wr,
  output logic              conflict
);
  localparam int EW = ADDR_W + 1;

  logic [EW-1:0] a_lo, a_hi, b_lo, b_hi;
  logic          span;

  always_comb begin
    a_lo = EW'(a_base);
    b_lo = EW'(b_base);
    a_hi = a_lo + EW'(a_size);
    b_hi = b_lo + EW'(b_size);
    span = (a_lo < b_hi) && (b_lo < a_hi);
    conflict = (a_wr || b_wr) && (a_size != '0) && (b_size != '0) && span;
  end

endmodule

// File: rtl/mdq_hazard.sv
module mdq_hazard #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 8,
  parameter int PTR_W  = 3
) (
  input  logic [ADDR_W-1:0] base_a [DEPTH],
  input  logic [SIZE_W-1:0] size_a [DEPTH],
  input  logic              wr_a   [DEPTH],
  input  logic [DEPTH-1:0]  live,
  input  logic [PTR_W-1:0]  head_idx,
  input  logic [PTR_W-1:0]  cand_idx,
  input  logic [PTR_W-1:0]  cand_off,
  output logic              blocked
);
  logic [DEPTH-1:0] hit;
  logic [ADDR_W-1:0] c_base;
  logic [SIZE_W-1:0] c_size;
  logic              c_wr;

  assign c_base = base_a[cand_idx];
  assign c_size = size_a[cand_idx];
  assign c_wr   = wr_a[cand_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [PTR_W-1:0] SLOT = PTR_W'(g);
    logic [PTR_W-1:0] age;
    logic             older;
    logic             ovl;

    assign age   = SLOT - head_idx;
    assign older = age < cand_off;

    mdq_overlap #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ovl (
      .a_base  (base_a[g]),
      .a_size  (size_a[g]),
      .a_wr    (wr_a[g]),
      .b_base  (c_base),
      .b_size  (c_size),
      .b_wr    (c_wr),
      .conflict(ovl)
    );

    assign hit[g] = live[g] && older && ovl;
  end

  assign blocked = |hit;

endmodule

// File: rtl/mdq_store.sv
module mdq_store
  import mdq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 8,
  parameter int TAG_W  = 4,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic              wr_write,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              iss_en,
  input  logic [PTR_W-1:0]  iss_idx,
  input  logic              cmp_en,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic              free_en,
  input  logic [PTR_W-1:0]  free_idx,
  output logic [ADDR_W-1:0] base_a [DEPTH],
  output logic [SIZE_W-1:0] size_a [DEPTH],
  output logic              wr_a   [DEPTH],
  output logic [TAG_W-1:0]  tag_a  [DEPTH],
  output slot_st_e          st_a   [DEPTH]
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam logic [PTR_W-1:0] SLOT = PTR_W'(g);

    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == SLOT) begin
        base_a[g] <= wr_base;
        size_a[g] <= wr_size;
        wr_a[g]   <= wr_write;
        tag_a[g]  <= wr_tag;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        st_a[g] <= ST_FREE;
      end else if (wr_en && wr_idx == SLOT) begin
        st_a[g] <= ST_WAIT;
      end else if (iss_en && iss_idx == SLOT) begin
        st_a[g] <= ST_ISS;
      end else if (cmp_en && st_a[g] == ST_ISS && tag_a[g] == cmp_tag) begin
        st_a[g] <= ST_DONE;
      end else if (free_en && free_idx == SLOT) begin
        st_a[g] <= ST_FREE;
      end
    end

    // R8: an entry only reaches the completed state from issued
    a_r8_done_from_issued: assert property (@(posedge clk) disable iff (rst)
      (st_a[g] == ST_DONE && $past(st_a[g]) != ST_DONE) |-> $past(st_a[g]) == ST_ISS);

    // R9: an entry is only freed after it completed
    a_r9_free_from_done: assert property (@(posedge clk) disable iff (rst)
      (st_a[g] == ST_FREE && $past(st_a[g]) != ST_FREE) |-> $past(st_a[g]) == ST_DONE);
  end

endmodule

// File: rtl/mdq_top.sv
module mdq_top
  import mdq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 8,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enq_valid,
  input  logic [ADDR_W-1:0] enq_base,
  input  logic [SIZE_W-1:0] enq_size,
  input  logic              enq_write,
  input  logic [TAG_W-1:0]  enq_tag,
  output logic              dsp_valid,
  input  logic              dsp_ready,
  output logic [ADDR_W-1:0] dsp_base,
  output logic [SIZE_W-1:0] dsp_size,
  output logic              dsp_write,
  output logic [TAG_W-1:0]  dsp_tag,
  input  logic              cmp_valid,
  input  logic [TAG_W-1:0]  cmp_tag,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  logic [CNT_W-1:0] wr_q, hd_q, ds_q;
  logic [CNT_W-1:0] wr_n, hd_n, ds_n;
  logic             full_q, empty_q;

  logic [PTR_W-1:0] wr_idx, hd_idx, ds_idx, cand_off;
  logic             cand_any, blocked;
  logic             enq_fire, dsp_fire, pop;

  logic [ADDR_W-1:0] base_a [DEPTH];
  logic [SIZE_W-1:0] size_a [DEPTH];
  logic              wr_a   [DEPTH];
  logic [TAG_W-1:0]  tag_a  [DEPTH];
  slot_st_e          st_a   [DEPTH];
  logic [DEPTH-1:0]  live;

  assign wr_idx   = wr_q[PTR_W-1:0];
  assign hd_idx   = hd_q[PTR_W-1:0];
  assign ds_idx   = ds_q[PTR_W-1:0];
  assign cand_any = (ds_q != wr_q);
  assign cand_off = PTR_W'(ds_q - hd_q);

  for (genvar g = 0; g < DEPTH; g++) begin : g_live
    assign live[g] = (st_a[g] == ST_WAIT) || (st_a[g] == ST_ISS);
  end

  assign enq_fire = enq_valid && !full_q;
  assign dsp_valid = cand_any && !blocked;
  assign dsp_fire = dsp_valid && dsp_ready;
  assign pop      = !empty_q && (st_a[hd_idx] == ST_DONE);

  assign dsp_base  = base_a[ds_idx];
  assign dsp_size  = size_a[ds_idx];
  assign dsp_write = wr_a[ds_idx];
  assign dsp_tag   = tag_a[ds_idx];

  assign full  = full_q;
  assign empty = empty_q;

  mdq_store #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .TAG_W(TAG_W), .PTR_W(PTR_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (enq_fire),
    .wr_idx  (wr_idx),
    .wr_base (enq_base),
    .wr_size (enq_size),
    .wr_write(enq_write),
    .wr_tag  (enq_tag),
    .iss_en  (dsp_fire),
    .iss_idx (ds_idx),
    .cmp_en  (cmp_valid),
    .cmp_tag (cmp_tag),
    .free_en (pop),
    .free_idx(hd_idx),
    .base_a  (base_a),
    .size_a  (size_a),
    .wr_a    (wr_a),
    .tag_a   (tag_a),
    .st_a    (st_a)
  );

  mdq_hazard #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .PTR_W(PTR_W)
  ) u_hazard (
    .base_a  (base_a),
    .size_a  (size_a),
    .wr_a    (wr_a),
    .live    (live),
    .head_idx(hd_idx),
    .cand_idx(ds_idx),
    .cand_off(cand_off),
    .blocked (blocked)
  );

  always_comb begin
    wr_n = wr_q + CNT_W'(enq_fire);
    hd_n = hd_q + CNT_W'(pop);
    ds_n = ds_q + CNT_W'(dsp_fire);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= '0;
      hd_q    <= '0;
      ds_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      wr_q    <= wr_n;
      hd_q    <= hd_n;
      ds_q    <= ds_n;
      full_q  <= (wr_n - hd_n) == CAP;
      empty_q <= (wr_n == hd_n);
    end
  end

  // R10: occupancy never exceeds the capacity
  a_r10_occupancy: assert property (@(posedge clk) disable iff (rst)
    (wr_q - hd_q) <= CAP);

  // R10: a full queue takes no new entry
  a_r10_full_hold: assert property (@(posedge clk) disable iff (rst)
    full_q |=> wr_q == $past(wr_q));

  // R7: the dispatch pointer stays between head and tail
  a_r7_cand_window: assert property (@(posedge clk) disable iff (rst)
    (ds_q - hd_q) <= (wr_q - hd_q));

  // R2: only a waiting entry is dispatched
  a_r2_dispatch_waiting: assert property (@(posedge clk) disable iff (rst)
    dsp_fire |-> st_a[ds_idx] == ST_WAIT);

  // R9: the empty flag agrees with the pointers
  a_r9_empty_flag: assert property (@(posedge clk) disable iff (rst)
    empty_q == (wr_q == hd_q));

endmodule

// File: tb/tb_mdq_top.sv
module tb_mdq_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int SIZE_W = 8;
  localparam int TAG_W  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              enq_valid = 1'b0;
  logic [ADDR_W-1:0] enq_base = '0;
  logic [SIZE_W-1:0] enq_size = '0;
  logic              enq_write = 1'b0;
  logic [TAG_W-1:0]  enq_tag = '0;
  logic              dsp_valid;
  logic              dsp_ready = 1'b0;
  logic [ADDR_W-1:0] dsp_base;
  logic [SIZE_W-1:0] dsp_size;
  logic              dsp_write;
  logic [TAG_W-1:0]  dsp_tag;
  logic              cmp_valid = 1'b0;
  logic [TAG_W-1:0]  cmp_tag = '0;
  logic              full;
  logic              empty;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdq_top #(.DEPTH(8), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .TAG_W(TAG_W)) dut (
    .clk(clk), .rst(rst),
    .enq_valid(enq_valid), .enq_base(enq_base), .enq_size(enq_size),
    .enq_write(enq_write), .enq_tag(enq_tag),
    .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_base(dsp_base),
    .dsp_size(dsp_size), .dsp_write(dsp_write), .dsp_tag(dsp_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .full(full), .empty(empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // all tasks start and end at a falling edge
  task automatic enq(input int b, input int s, input bit w, input int t);
    enq_valid = 1'b1; enq_base = ADDR_W'(b); enq_size = SIZE_W'(s);
    enq_write = w; enq_tag = TAG_W'(t);
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic disp();
    dsp_ready = 1'b1;
    @(negedge clk);
    dsp_ready = 1'b0;
  endtask

  task automatic cmp(input int t);
    cmp_valid = 1'b1; cmp_tag = TAG_W'(t);
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk_eq("R1 empty", int'(empty), 1);
    chk_eq("R1 full", int'(full), 0);
    chk_eq("R1 dsp_valid", int'(dsp_valid), 0);
  endtask

  task automatic t_raw();
    enq(16'h0100, 16, 1'b1, 1);
    chk_eq("R2 valid", int'(dsp_valid), 1);
    chk_eq("R2 tag", int'(dsp_tag), 1);
    chk_eq("R2 base", int'(dsp_base), 16'h0100);
    chk_eq("R2 size", int'(dsp_size), 16);
    chk_eq("R2 write", int'(dsp_write), 1);
    enq(16'h0108, 4, 1'b0, 2);
    chk_eq("R2 oldest offered", int'(dsp_tag), 1);
    disp();
    chk_eq("R3 raw held", int'(dsp_valid), 0);
    cmp(1);
    chk_eq("R8 released valid", int'(dsp_valid), 1);
    chk_eq("R8 released tag", int'(dsp_tag), 2);
    disp();
    cmp(2);
    chk_eq("R9 not yet empty", int'(empty), 0);
    step(1);
    chk_eq("R9 empty after retire", int'(empty), 1);
  endtask

  task automatic t_war();
    enq(16'h0300, 8, 1'b0, 3);
    enq(16'h0304, 8, 1'b1, 4);
    disp();
    chk_eq("R3 war held", int'(dsp_valid), 0);
    cmp(3);
    chk_eq("R3 war released", int'(dsp_valid), 1);
    chk_eq("R3 war tag", int'(dsp_tag), 4);
    disp();
    cmp(4);
    step(1);
    chk_eq("R9 empty war", int'(empty), 1);
  endtask

  task automatic t_rar();
    enq(16'h0400, 16, 1'b0, 5);
    enq(16'h0404, 4, 1'b0, 6);
    disp();
    chk_eq("R4 rar valid", int'(dsp_valid), 1);
    chk_eq("R4 rar tag", int'(dsp_tag), 6);
    disp();
    cmp(5);
    cmp(6);
    step(1);
    chk_eq("R9 empty rar", int'(empty), 1);
  endtask

  task automatic t_edges();
    enq(16'h0500, 16, 1'b1, 7);
    enq(16'h0510, 8, 1'b1, 8);
    disp();
    chk_eq("R5 touching valid", int'(dsp_valid), 1);
    chk_eq("R5 touching tag", int'(dsp_tag), 8);
    disp();
    enq(16'h050F, 1, 1'b1, 9);
    chk_eq("R5 one byte held", int'(dsp_valid), 0);
    cmp(7);
    chk_eq("R5 one byte released", int'(dsp_valid), 1);
    chk_eq("R5 one byte tag", int'(dsp_tag), 9);
    disp();
    cmp(8);
    cmp(9);
    step(1);
    chk_eq("R9 empty edges", int'(empty), 1);
  endtask

  task automatic t_zero();
    enq(16'h0600, 16, 1'b1, 10);
    disp();
    enq(16'h0604, 0, 1'b1, 11);
    chk_eq("R6 zero valid", int'(dsp_valid), 1);
    chk_eq("R6 zero tag", int'(dsp_tag), 11);
    disp();
    cmp(10);
    cmp(11);
    step(1);
    chk_eq("R9 empty zero", int'(empty), 1);
  endtask

  task automatic t_order();
    enq(16'h0700, 8, 1'b1, 12);
    disp();
    enq(16'h0700, 4, 1'b0, 13);
    enq(16'h0900, 4, 1'b0, 14);
    chk_eq("R7 younger not offered", int'(dsp_valid), 0);
    cmp(12);
    chk_eq("R7 oldest first", int'(dsp_tag), 13);
    disp();
    chk_eq("R7 then younger valid", int'(dsp_valid), 1);
    chk_eq("R7 then younger tag", int'(dsp_tag), 14);
    disp();
    cmp(13);
    cmp(14);
    step(1);
    chk_eq("R9 empty order", int'(empty), 1);
  endtask

  task automatic t_full();
    for (int k = 0; k < 8; k++) enq(16'h1000 + 16 * k, 4, 1'b0, k);
    chk_eq("R10 full", int'(full), 1);
    enq(16'h2000, 4, 1'b1, 9);
    chk_eq("R10 still full", int'(full), 1);
    for (int k = 0; k < 8; k++) begin
      chk_eq("R10 drain valid", int'(dsp_valid), 1);
      chk_eq("R10 drain tag", int'(dsp_tag), k);
      disp();
    end
    chk_eq("R10 dropped entry absent", int'(dsp_valid), 0);
    cmp(1);
    step(1);
    chk_eq("R9 head not done keeps full", int'(full), 1);
    cmp(0);
    chk_eq("R9 retire waits one cycle", int'(full), 1);
    step(1);
    chk_eq("R9 head retired", int'(full), 0);
    for (int k = 2; k < 8; k++) cmp(k);
    step(3);
    chk_eq("R9 drained empty", int'(empty), 1);
    chk_eq("R10 nothing left", int'(dsp_valid), 0);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_raw();
    t_war();
    t_rar();
    t_edges();
    t_zero();
    t_order();
    t_full();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule